// File: doc/BRIEF.md
# Scan Chain State Controller

This block sequences a serial scan chain that links every flip-flop of an emulated design into one long shift register. A single pass shifts the whole chain by exactly `CHAIN_LEN` positions. While the host's new state is streamed in, the old state streams out, so capture and restore happen in the same pass. Host data arrives and leaves as 32-bit words on two valid/ready streams, least significant bit first. The final partial word is padded with zeros on capture, and its unused bits are ignored on load.

The design under emulation has no asynchronous reset network. Its reset values are loaded by running one pass right after the controller's own reset. Until that first pass completes, the design clock enable is held off. After that it follows the host's run request, but only while no pass is in progress. A scan shift and a functional clock enable are therefore never active in the same cycle. Large memories are outside the chain and are reached through separate host ports, not through this block.

Back-pressure rules:
- The controller asks for an input word (`in_ready`) only when it has no bits left to shift. It then waits for `in_valid`.
- A captured word is held on `out_data` with `out_valid` high until `out_ready` accepts it.
- No shifting occurs while a word is missing or a capture is pending.

Top module: `scan_state_ctrl`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `busy`, `done`, `scan_en`, `in_ready`, `out_valid`, `init_done` and `dut_clk_en` are all 0.
- R2: A `start` pulse seen while idle makes `busy` 1 from the next cycle. A `start` seen while busy is ignored and begins no extra pass. When idle, `in_ready` stays 0 whatever `in_valid` does.
- R3: Each pass asserts `scan_en` for exactly `CHAIN_LEN` cycles, counted from the accepted `start` to the `done` pulse.
- R4: `scan_en` and `dut_clk_en` are never 1 in the same cycle. `dut_clk_en` equals `run_req` whenever the block is idle and initialised.
- R5: Bit j of input word k (j = 0 is the LSB) is driven on `scan_in` in shift number 32k+j of the pass. Input bits at positions CHAIN_LEN and beyond are not shifted.
- R6: Bit j of output word k equals the `scan_out` value present in shift 32k+j. Bits at positions CHAIN_LEN and beyond are 0.
- R7: `scan_en` is 0 while an input word is awaited or a captured word is pending. While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_data` are held in the next cycle.
- R8: `done` pulses for one cycle after the last output word is accepted, and `busy` is 0 from then on. `init_done` becomes 1 at the first `done` and stays 1. Before that, `dut_clk_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared with the chain |
| rst_n | input | 1 | Synchronous active-low reset of the controller |
| start | input | 1 | Request one full capture/restore pass |
| busy | output | 1 | A pass is in progress |
| done | output | 1 | One-cycle pulse at the end of a pass |
| init_done | output | 1 | The first pass (startup values) has completed |
| run_req | input | 1 | Host request to clock the design functionally |
| dut_clk_en | output | 1 | Functional clock enable for the design |
| in_valid | input | 1 | Restore word available |
| in_ready | output | 1 | Controller accepts a restore word |
| in_data | input | 32 | Restore word, LSB shifted first |
| out_valid | output | 1 | Captured word available |
| out_ready | input | 1 | Host accepts the captured word |
| out_data | output | 32 | Captured word, first bit out in the LSB |
| scan_en | output | 1 | Shift the chain this cycle |
| scan_in | output | 1 | Bit entering the chain |
| scan_out | input | 1 | Bit leaving the chain |

## Verification
The hardest case to reach is the shift boundary where a partial last word meets back-pressure on both streams. There, a stall must freeze the bit count mid-pass without losing or repeating a chain bit. The bench uses a 70-bit chain, so the last word carries 6 bits. It runs several passes with different data seeds and with input and output stalls inserted at every word. Each capture is compared with the chain image recorded before the pass, and the chain image after the pass is compared with the words that were sent. Each pass therefore also checks that the previous pass restored its data exactly.

// File: rtl/scan_ctrl_pkg.sv
package scan_ctrl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_DRAIN = 2'd3
  } scan_state_e;
endpackage

// File: rtl/scan_word_serializer.sv
module scan_word_serializer #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              shift,
  input  logic [WORD_W-1:0] din,
  output logic              sbit
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     sh_q <= '0;
    else if (load)  sh_q <= din;
    else if (shift) sh_q <= sh_q >> 1;
  end

  assign sbit = sh_q[0];
endmodule

// File: rtl/scan_word_capture.sv
module scan_word_capture #(
  parameter int WORD_W = 32,
  localparam int BW = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              shift,
  input  logic [BW-1:0]     bit_idx,
  input  logic              sbit,
  output logic [WORD_W-1:0] word
);
  for (genvar g = 0; g < WORD_W; g++) begin : g_bit
    logic b_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clear)                       b_q <= 1'b0;
      else if (shift && bit_idx == BW'(g))       b_q <= sbit;
    end
    assign word[g] = b_q;
  end
endmodule

// File: rtl/scan_seq_fsm.sv
module scan_seq_fsm
  import scan_ctrl_pkg::*;
#(
  parameter int CHAIN_LEN = 70,
  parameter int WORD_W    = 32,
  localparam int BW       = $clog2(WORD_W),
  localparam int NWORDS   = (CHAIN_LEN + WORD_W - 1) / WORD_W,
  localparam int WCW      = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          in_valid,
  input  logic          out_ready,
  output scan_state_e   state,
  output logic [BW-1:0] bit_idx,
  output logic          load,
  output logic          shift,
  output logic          done,
  output logic          init_done
);
  localparam int LAST_BITS = CHAIN_LEN - WORD_W * (NWORDS - 1);
  localparam logic [BW-1:0]  FULL_IDX = BW'(WORD_W - 1);
  localparam logic [BW-1:0]  LAST_IDX = BW'(LAST_BITS - 1);
  localparam logic [WCW-1:0] LAST_WORD = WCW'(NWORDS - 1);

  scan_state_e    state_q;
  logic [BW-1:0]  bit_q;
  logic [WCW-1:0] word_q;
  logic           done_q, init_q;
  logic           last_word, word_end, accept_out;

  assign last_word  = (word_q == LAST_WORD);
  assign word_end   = (bit_q == (last_word ? LAST_IDX : FULL_IDX));
  assign load       = (state_q == ST_LOAD) && in_valid;
  assign shift      = (state_q == ST_SHIFT);
  assign accept_out = (state_q == ST_DRAIN) && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      word_q  <= '0;
      done_q  <= 1'b0;
      init_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOAD;
          word_q  <= '0;
        end
        ST_LOAD: if (in_valid) begin
          state_q <= ST_SHIFT;
          bit_q   <= '0;
        end
        ST_SHIFT: begin
          if (word_end) state_q <= ST_DRAIN;
          else          bit_q   <= bit_q + 1'b1;
        end
        ST_DRAIN: if (accept_out) begin
          if (last_word) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
            init_q  <= 1'b1;
          end else begin
            state_q <= ST_LOAD;
            word_q  <= word_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign state     = state_q;
  assign bit_idx   = bit_q;
  assign done      = done_q;
  assign init_done = init_q;
endmodule

// File: rtl/scan_state_ctrl.sv
module scan_state_ctrl
  import scan_ctrl_pkg::*;
#(
  parameter int CHAIN_LEN = 70,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              init_done,
  input  logic              run_req,
  output logic              dut_clk_en,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              scan_en,
  output logic              scan_in,
  input  logic              scan_out
);
  localparam int BW = $clog2(WORD_W);

  scan_state_e   state;
  logic [BW-1:0] bit_idx;
  logic          load, shift;

  scan_seq_fsm #(.CHAIN_LEN(CHAIN_LEN), .WORD_W(WORD_W)) i_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .state(state), .bit_idx(bit_idx),
    .load(load), .shift(shift), .done(done), .init_done(init_done)
  );

  scan_word_serializer #(.WORD_W(WORD_W)) i_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .din(in_data), .sbit(scan_in)
  );

  scan_word_capture #(.WORD_W(WORD_W)) i_cap (
    .clk(clk), .rst_n(rst_n), .clear(load), .shift(shift),
    .bit_idx(bit_idx), .sbit(scan_out), .word(out_data)
  );

  assign busy       = (state != ST_IDLE);
  assign in_ready   = (state == ST_LOAD);
  assign out_valid  = (state == ST_DRAIN);
  assign scan_en    = shift;
  assign dut_clk_en = run_req && init_done && (state == ST_IDLE);
endmodule

// File: rtl/scan_state_ctrl_chk.sv
module scan_state_ctrl_chk #(
  parameter int CHAIN_LEN = 70,
  parameter int WORD_W    = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              init_done,
  input logic              run_req,
  input logic              dut_clk_en,
  input logic              in_valid,
  input logic              in_ready,
  input logic [WORD_W-1:0] in_data,
  input logic              out_valid,
  input logic              out_ready,
  input logic [WORD_W-1:0] out_data,
  input logic              scan_en,
  input logic              scan_in,
  input logic              scan_out
);
  logic [31:0] shift_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                shift_cnt <= '0;
    else if (start && !busy)   shift_cnt <= '0;
    else if (scan_en)          shift_cnt <= shift_cnt + 1;
  end

  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> !dut_clk_en);

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R7
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready || out_valid) |-> !scan_en);

  // R3
  shift_total_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (shift_cnt == 32'(CHAIN_LEN)));

  // R8
  init_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (init_done && !busy));

  // R2
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start) |=> busy);
endmodule

bind scan_state_ctrl scan_state_ctrl_chk #(.CHAIN_LEN(CHAIN_LEN), .WORD_W(WORD_W)) i_chk (.*);

// File: tb/test_scan_state_ctrl.sv
module test_scan_state_ctrl;
  localparam int L  = 70;
  localparam int W  = 32;
  localparam int NW = (L + W - 1) / W;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, run_req = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic busy, done, init_done, dut_clk_en, in_ready, out_valid;
  logic [W-1:0] out_data;
  logic scan_en, scan_in, scan_out;

  int checks = 0, fails = 0, shifts = 0, done_cnt = 0, overlap = 0;
  logic [L-1:0] chain;

  always #2 clk = ~clk;

  scan_state_ctrl #(.CHAIN_LEN(L), .WORD_W(W)) i_scan_state_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .init_done(init_done), .run_req(run_req), .dut_clk_en(dut_clk_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out)
  );

  function automatic logic [L-1:0] boot_image();
    logic [L-1:0] v;
    for (int i = 0; i < L; i++) v[i] = ((i * 7) % 3 == 0);
    return v;
  endfunction

  assign scan_out = chain[L-1];
  always @(posedge clk) begin
    if (!rst_n) chain <= boot_image();
    else if (scan_en) chain <= {chain[L-2:0], scan_in};
  end
  always @(posedge clk) if (scan_en) shifts <= shifts + 1;
  always @(negedge clk) begin
    if (done) done_cnt <= done_cnt + 1;
    if (scan_en && dut_clk_en) overlap <= overlap + 1;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_pass(input logic [W-1:0] seed, input int gap);
    logic [W-1:0] win [NW];
    logic [W-1:0] wout [NW];
    logic [L-1:0] snap;
    logic [W-1:0] held;
    int s0, d0, guard;
    for (int k = 0; k < NW; k++) win[k] = seed ^ (W'(k) * 32'h9E37_79B9);
    snap = chain; s0 = shifts; d0 = done_cnt;
    start = 1'b1;
    @(negedge clk);
    chk(busy == 1'b1, "R2 busy after start", {31'b0, busy}, 1);
    @(negedge clk);
    start = 1'b0;  // second cycle of start was seen while busy
    for (int k = 0; k < NW; k++) begin
      repeat (gap) begin
        chk(scan_en == 1'b0 && in_ready == 1'b1, "R7 stall without input", {31'b0, scan_en}, 0);
        @(negedge clk);
      end
      in_valid = 1'b1; in_data = win[k];
      guard = 0;
      while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
      @(negedge clk);
      in_valid = 1'b0; in_data = '0;
      guard = 0;
      while (!out_valid && guard < 100) begin @(negedge clk); guard++; end
      held = out_data;
      repeat (gap) begin
        @(negedge clk);
        chk(out_valid && out_data == held && !scan_en, "R7 output held", out_data, held);
      end
      out_ready = 1'b1; wout[k] = out_data;
      @(negedge clk);
      out_ready = 1'b0;
    end
    @(negedge clk);
    chk(done_cnt == d0 + 1, "R8 single done pulse", W'(done_cnt - d0), 1);
    chk(busy == 1'b0 && init_done == 1'b1, "R8 idle and initialised", {30'b0, busy, init_done}, 1);
    chk(shifts - s0 == L, "R3 shift count", W'(shifts - s0), W'(L));
    for (int k = 0; k < NW; k++) begin
      logic [W-1:0] ec, ac, ei;
      ec = '0; ac = '0; ei = '0;
      for (int j = 0; j < W; j++) begin
        int n;
        n = k * W + j;
        if (n < L) begin
          ec[j] = snap[L-1-n];
          ac[j] = chain[L-1-n];
          ei[j] = win[k][j];
        end
      end
      chk(wout[k] == ec, "R6 captured word", wout[k], ec);
      chk(ac == ei, "R5 restored chain bits", ac, ei);
    end
    s0 = shifts;
    in_valid = 1'b1; in_data = 32'hFFFF_FFFF;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready == 1'b0 && busy == 1'b0, "R2 no request when idle", {31'b0, in_ready}, 0);
    end
    in_valid = 1'b0; in_data = '0;
    chk(shifts == s0, "R2 ignored start gave no extra shifts", W'(shifts - s0), 0);
  endtask

  initial begin
    run_req = 1'b1;
    repeat (3) @(negedge clk);
    chk({busy, done, scan_en, in_ready, out_valid, init_done, dut_clk_en} == 7'b0,
        "R1 reset outputs", {25'b0, busy, done, scan_en, in_ready, out_valid, init_done, dut_clk_en}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({busy, done, scan_en, in_ready, out_valid, init_done} == 6'b0,
        "R1 after reset", {26'b0, busy, done, scan_en, in_ready, out_valid, init_done}, 0);
    chk(dut_clk_en == 1'b0, "R8 clock held before init", {31'b0, dut_clk_en}, 0);
    do_pass(32'h0000_0000, 0);
    chk(dut_clk_en == 1'b1, "R4 clock follows run when idle", {31'b0, dut_clk_en}, 1);
    run_req = 1'b0;
    @(negedge clk);
    chk(dut_clk_en == 1'b0, "R4 clock off with run low", {31'b0, dut_clk_en}, 0);
    run_req = 1'b1;
    do_pass(32'hA5C3_0F96, 3);
    do_pass(32'hFFFF_FFFF, 1);
    do_pass(32'h1234_5678, 2);
    do_pass(32'h5555_AAAA, 0);
    chk(overlap == 0, "R4 no scan during functional clock", W'(overlap), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule